// File: doc/BRIEF.md
# Down-Counting Timer with Watchdog Mode

This block is a register-mapped down-counter. It has two jobs. As a timer it counts down to zero, raises an interrupt, and either reloads itself for periodic operation or stops. As a watchdog it asserts a one-cycle reset request when the count runs out, and it records that cause in a flag that software clears by writing 1.

Counting is paced by an external `tick_i` strobe. An 8-bit prescaler divides that strobe. Software programs a period as "steps minus one" by writing the load register, which loads the counter at the same time.

Once watchdog mode is entered, a plain control write cannot clear it. The only way back to timer mode is to write two fixed words, in order, to a write-only unlock offset.

Top module: `twd_timer`

## Requirements
- R1: After reset every readable register reads 0, `irq_o` is low and `wdog_rst_o` is low.
- R2: Writing offset 0x0 sets the load register and the counter to the written value. Offset 0x4 returns the live count. Writes to offset 0x4 have no effect.
- R3: The counter moves only while control bit 0 (run) is 1. It then decrements by one on every (P+1)-th high cycle of `tick_i`, where P is control bits 15:8. While run is 0 the count holds.
- R4: A decrement step taken while the count is 0 is an expiry, so a load value L gives a period of L+1 steps. On expiry with control bit 1 (reload) set, the counter restarts from the load register. With reload clear, the counter stays at 0 and hardware clears the run bit.
- R5: When control bit 3 is 0, an expiry sets bit 0 of the status register at 0xC. `irq_o` equals that bit ANDed with control bit 2 (interrupt enable). Writing 1 to bit 0 clears it. Writing 0 to it changes nothing.
- R6: When control bit 3 (watchdog) is 1, an expiry drives `wdog_rst_o` high for one cycle and sets bit 0 of the register at 0x10. The interrupt status and `irq_o` stay low whatever bit 2 holds. Bit 0 at 0x10 is cleared by writing 1 to it.
- R7: A control write with bit 3 equal to 0 leaves bit 3 at 1 once it is set. All other control fields take the written value.
- R8: Writing 0x12345678 and then 0x87654321 as two consecutive writes to offset 0x14 clears control bit 3. Accesses to other offsets between the two writes do not break the sequence.
- R9: Any other value written to 0x14 after the first word abandons the sequence, and a later second word does nothing. Reads of 0x14 return 0.
- R10: Control reads return run, reload, interrupt enable and watchdog in bits 0 to 3 and the prescaler in bits 15:8. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tick_i | input | 1 | Count pacing strobe, synchronous to clk |
| bus_sel | input | 1 | Register access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset; bits 4:2 select the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| irq_o | output | 1 | Timer interrupt, level |
| wdog_rst_o | output | 1 | Watchdog reset request, one cycle per expiry |

## Verification
The properties assume one register access per cycle. They also assume `tick_i` is a clean synchronous level and that nothing writes the control register in the same cycle as a one-shot expiry. The stimulus drives every access on the falling edge for exactly one cycle. It holds `tick_i` steady across each measurement and switches the timer off before it reprograms a period, so no control write lands on an expiry edge. Expiry latencies are measured edge by edge from the enabling write and compared with (L+1)·(P+1).

// File: rtl/twd_pkg.sv
package twd_pkg;
  // word index (byte offset bits 4:2)
  localparam logic [2:0] IDX_LOAD   = 3'd0;
  localparam logic [2:0] IDX_COUNT  = 3'd1;
  localparam logic [2:0] IDX_CTRL   = 3'd2;
  localparam logic [2:0] IDX_STAT   = 3'd3;
  localparam logic [2:0] IDX_RCAUSE = 3'd4;
  localparam logic [2:0] IDX_UNLOCK = 3'd5;

  localparam logic [31:0] UNLOCK_A = 32'h1234_5678;
  localparam logic [31:0] UNLOCK_B = 32'h8765_4321;

  // control field bit positions
  localparam int unsigned CB_RUN   = 0;
  localparam int unsigned CB_RELD  = 1;
  localparam int unsigned CB_IEN   = 2;
  localparam int unsigned CB_WDOG  = 3;
  localparam int unsigned CB_PRE   = 8;
endpackage

// File: rtl/twd_rst_sync.sv
module twd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_sync_n = s2_q;
endmodule

// File: rtl/twd_prescale.sv
module twd_prescale #(
  parameter int unsigned PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             clr_i,
  input  logic             tick_i,
  input  logic [PRE_W-1:0] div_i,
  output logic             step_o
);
  logic [PRE_W-1:0] pcnt_q, pcnt_d;
  logic             hit;

  assign hit    = (pcnt_q >= div_i);
  assign step_o = en_i & tick_i & hit & ~clr_i;

  always_comb begin
    pcnt_d = pcnt_q;
    if (!en_i || clr_i)
      pcnt_d = '0;
    else if (tick_i)
      pcnt_d = hit ? '0 : pcnt_q + PRE_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt_q <= '0;
    else        pcnt_q <= pcnt_d;
  end

  // R3: stopping or reloading restarts the division phase
  a_r3_phase_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i || clr_i) |=> (pcnt_q == '0));
endmodule

// File: rtl/twd_downcnt.sv
module twd_downcnt #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_i,
  input  logic             load_wr_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             reload_en_i,
  input  logic [CNT_W-1:0] reload_val_i,
  output logic [CNT_W-1:0] count_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] count_q, count_d;
  logic             zero;

  assign zero     = (count_q == '0);
  assign expire_o = step_i & zero & ~load_wr_i;
  assign count_o  = count_q;

  always_comb begin
    count_d = count_q;
    if (load_wr_i)
      count_d = load_val_i;
    else if (step_i) begin
      if (zero) count_d = reload_en_i ? reload_val_i : count_q;
      else      count_d = count_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= count_d;
  end

  a_r3_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_i && !load_wr_i) |=> $stable(count_q));
  a_r3_step_dec: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !zero && !load_wr_i) |=> (count_q == $past(count_q) - CNT_W'(1)));
  a_r4_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_o && reload_en_i) |=> (count_q == $past(reload_val_i)));
  a_r2_load_takes: assert property (@(posedge clk) disable iff (!rst_n)
    load_wr_i |=> (count_q == $past(load_val_i)));
endmodule

// File: rtl/twd_unlock.sv
module twd_unlock
  import twd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_i,
  input  logic [31:0] wdata_i,
  output logic        unlock_o
);
  logic armed_q, armed_d;

  always_comb begin
    armed_d = armed_q;
    if (wr_i) armed_d = (wdata_i == UNLOCK_A);
  end

  assign unlock_o = wr_i & armed_q & (wdata_i == UNLOCK_B);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= armed_d;
  end

  a_r9_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && wdata_i != UNLOCK_A) |=> !armed_q);
  a_r8_arm: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && wdata_i == UNLOCK_A) |=> armed_q);
endmodule

// File: rtl/twd_timer.sv
module twd_timer
  import twd_pkg::*;
#(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned PRE_W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_i,
  input  logic        bus_sel,
  input  logic        bus_we,
  input  logic [4:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq_o,
  output logic        wdog_rst_o
);
  localparam int unsigned PRE_HI = CB_PRE + PRE_W - 1;

  logic             rs_n;
  logic [2:0]       idx;
  logic             wr, wr_load, wr_ctl, wr_stat, wr_rc, wr_unl;
  logic             unused_addr;

  logic             run_q, run_d, reld_q, reld_d, ien_q, ien_d, wd_q, wd_d;
  logic [PRE_W-1:0] pre_q, pre_d;
  logic             st_q, st_d, rc_q, rc_d, rst_q, rst_d;
  logic [CNT_W-1:0] load_q, load_d;
  logic [CNT_W-1:0] count;
  logic             step, expire, unlock;

  twd_rst_sync u_rsync (.clk(clk), .rst_n(rst_n), .rst_sync_n(rs_n));

  assign idx         = bus_addr[4:2];
  assign unused_addr = ^bus_addr[1:0];
  assign wr          = bus_sel & bus_we;
  assign wr_load     = wr & (idx == IDX_LOAD);
  assign wr_ctl      = wr & (idx == IDX_CTRL);
  assign wr_stat     = wr & (idx == IDX_STAT);
  assign wr_rc       = wr & (idx == IDX_RCAUSE);
  assign wr_unl      = wr & (idx == IDX_UNLOCK);

  twd_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rs_n), .en_i(run_q), .clr_i(wr_load),
    .tick_i(tick_i), .div_i(pre_q), .step_o(step));

  twd_downcnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rs_n), .step_i(step), .load_wr_i(wr_load),
    .load_val_i(bus_wdata[CNT_W-1:0]), .reload_en_i(reld_q),
    .reload_val_i(load_q), .count_o(count), .expire_o(expire));

  twd_unlock u_unl (
    .clk(clk), .rst_n(rs_n), .wr_i(wr_unl), .wdata_i(bus_wdata),
    .unlock_o(unlock));

  // next state
  always_comb begin
    run_d  = run_q;
    reld_d = reld_q;
    ien_d  = ien_q;
    wd_d   = wd_q;
    pre_d  = pre_q;
    if (wr_ctl) begin
      run_d  = bus_wdata[CB_RUN];
      reld_d = bus_wdata[CB_RELD];
      ien_d  = bus_wdata[CB_IEN];
      wd_d   = wd_q | bus_wdata[CB_WDOG];
      pre_d  = bus_wdata[PRE_HI:CB_PRE];
    end else if (expire && !reld_q) begin
      run_d  = 1'b0;
    end
    if (unlock) wd_d = 1'b0;
  end

  always_comb begin
    load_d = wr_load ? bus_wdata[CNT_W-1:0] : load_q;
    st_d   = st_q;
    if (wr_stat && bus_wdata[0]) st_d = 1'b0;
    if (expire && !wd_q)         st_d = 1'b1;
    rc_d   = rc_q;
    if (wr_rc && bus_wdata[0])   rc_d = 1'b0;
    if (expire && wd_q)          rc_d = 1'b1;
    rst_d  = expire & wd_q;
  end

  // registers
  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) begin
      run_q  <= 1'b0;
      reld_q <= 1'b0;
      ien_q  <= 1'b0;
      wd_q   <= 1'b0;
      pre_q  <= '0;
      load_q <= '0;
      st_q   <= 1'b0;
      rc_q   <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      run_q  <= run_d;
      reld_q <= reld_d;
      ien_q  <= ien_d;
      wd_q   <= wd_d;
      pre_q  <= pre_d;
      load_q <= load_d;
      st_q   <= st_d;
      rc_q   <= rc_d;
      rst_q  <= rst_d;
    end
  end

  assign irq_o      = st_q & ien_q & ~wd_q;
  assign wdog_rst_o = rst_q;

  // read mux
  always_comb begin
    bus_rdata = '0;
    unique case (idx)
      IDX_LOAD:   bus_rdata = 32'(load_q);
      IDX_COUNT:  bus_rdata = 32'(count);
      IDX_CTRL: begin
        bus_rdata[CB_RUN]        = run_q;
        bus_rdata[CB_RELD]       = reld_q;
        bus_rdata[CB_IEN]        = ien_q;
        bus_rdata[CB_WDOG]       = wd_q;
        bus_rdata[PRE_HI:CB_PRE] = pre_q;
      end
      IDX_STAT:   bus_rdata[0] = st_q;
      IDX_RCAUSE: bus_rdata[0] = rc_q;
      default:    bus_rdata = '0;
    endcase
  end

  a_r7_mode_sticky: assert property (@(posedge clk) disable iff (!rs_n)
    (wd_q && !unlock) |=> wd_q);
  a_r6_rst_sets_cause: assert property (@(posedge clk) disable iff (!rs_n)
    wdog_rst_o |-> rc_q);
  a_r6_rst_from_wdog: assert property (@(posedge clk) disable iff (!rs_n)
    wdog_rst_o |-> $past(wd_q));
  a_r4_oneshot_stops: assert property (@(posedge clk) disable iff (!rs_n)
    (expire && !reld_q && !wr_ctl) |=> !run_q);
endmodule

// File: tb/twd_timer_bench.sv
`timescale 1ns/1ps
module twd_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o, wdog_rst_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  localparam logic [4:0] A_LOAD = 5'h00, A_CNT = 5'h04, A_CTL = 5'h08,
                         A_ST = 5'h0C, A_RC = 5'h10, A_UNL = 5'h14;

  // vectors: load, prescale, reload, expected edges to expiry = (L+1)*(P+1)
  localparam int NV = 8;
  localparam int V_LOAD [NV] = '{0, 1, 5, 3, 0, 7, 2, 10};
  localparam int V_PRE  [NV] = '{0, 0, 0, 2, 3, 1, 7, 0};
  localparam int V_REL  [NV] = '{1, 0, 1, 0, 1, 0, 1, 0};
  localparam int V_EXP  [NV] = '{1, 2, 6, 12, 4, 16, 24, 11};

  always #2.5 clk = ~clk;

  twd_timer u_twd_timer (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .bus_sel(bus_sel),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_o(irq_o), .wdog_rst_o(wdog_rst_o));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1;
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #0.5;
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run hung actual=running expected=finished");
      report();
    end
  end

  initial begin
    logic [31:0] v;
    int n;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 irq", 32'(irq_o), 0);
    chk("R1 rst", 32'(wdog_rst_o), 0);
    rd(A_LOAD, v); chk("R1 load", v, 0);
    rd(A_CNT, v);  chk("R1 count", v, 0);
    rd(A_CTL, v);  chk("R1 ctrl", v, 0);
    rd(A_ST, v);   chk("R1 status", v, 0);
    rd(A_RC, v);   chk("R1 cause", v, 0);

    // R10 control readback masks unused bits
    wr(A_CTL, 32'hFFFF_FFF7);
    rd(A_CTL, v); chk("R10 ctrl readback", v, 32'h0000_FF07);
    wr(A_CTL, 0);

    // R2 load and read-only count
    wr(A_LOAD, 32'h0000_1234);
    rd(A_LOAD, v); chk("R2 load reg", v, 32'h1234);
    rd(A_CNT, v);  chk("R2 count loaded", v, 32'h1234);
    wr(A_CNT, 32'h5);
    rd(A_CNT, v);  chk("R2 count write ignored", v, 32'h1234);

    // R3 hold while stopped
    tick_i = 1'b1;
    repeat (10) @(posedge clk);
    #1 rd(A_CNT, v); chk("R3 hold when stopped", v, 32'h1234);

    // R3 prescaled decrement: P=3, 8 edges -> 2 steps
    wr(A_LOAD, 100);
    wr(A_CTL, 32'h0000_0301);
    repeat (8) @(posedge clk);
    #1 rd(A_CNT, v); chk("R3 prescaled count", v, 98);
    wr(A_CTL, 0);

    // R4/R5 vector table
    for (int i = 0; i < NV; i++) begin
      wr(A_CTL, 0);
      wr(A_ST, 1);
      wr(A_LOAD, V_LOAD[i]);
      chk("R5 irq low before start", 32'(irq_o), 0);
      wr(A_CTL, 32'h5 | (V_REL[i] << 1) | (V_PRE[i] << 8));
      n = 0;
      do begin
        @(posedge clk); #1; n++;
      end while (!irq_o && n < 1000);
      chk("R4 expiry latency", n, V_EXP[i]);
      rd(A_CNT, v);
      chk("R4 count after expiry", v, V_REL[i] ? V_LOAD[i] : 0);
      rd(A_CTL, v);
      chk("R4 run bit after expiry", v & 1, V_REL[i] ? 1 : 0);
    end

    // R5 write-one-to-clear (last vector was one-shot, irq held)
    wr(A_ST, 0);
    chk("R5 write 0 keeps irq", 32'(irq_o), 1);
    wr(A_ST, 1);
    chk("R5 write 1 clears irq", 32'(irq_o), 0);

    // R6 watchdog expiry, interrupt enable ignored
    wr(A_CTL, 0);
    wr(A_LOAD, 3);
    wr(A_CTL, 32'h0000_000D);
    n = 0;
    do begin
      @(posedge clk); #1; n++;
    end while (!wdog_rst_o && n < 1000);
    chk("R6 reset latency", n, 4);
    chk("R6 irq stays low", 32'(irq_o), 0);
    rd(A_RC, v); chk("R6 cause flag", v, 1);
    rd(A_ST, v); chk("R6 status untouched", v, 0);
    @(posedge clk); #1;
    chk("R6 reset one cycle", 32'(wdog_rst_o), 0);

    // R7 mode sticky
    wr(A_CTL, 0);
    rd(A_CTL, v); chk("R7 mode stays set", v, 32'h8);

    // R9 abandoned sequence
    wr(A_UNL, 32'h1234_5678);
    wr(A_UNL, 32'h0000_DEAD);
    wr(A_UNL, 32'h8765_4321);
    rd(A_CTL, v); chk("R9 abandoned unlock", v, 32'h8);
    rd(A_UNL, v); chk("R9 unlock reads 0", v, 0);

    // R8 sequence with interleaved access
    wr(A_UNL, 32'h1234_5678);
    wr(A_LOAD, 5);
    wr(A_UNL, 32'h8765_4321);
    rd(A_CTL, v); chk("R8 unlock clears mode", v, 0);

    // R6 cause flag write-one-to-clear
    wr(A_RC, 0);
    rd(A_RC, v); chk("R6 cause write 0 kept", v, 1);
    wr(A_RC, 1);
    rd(A_RC, v); chk("R6 cause cleared", v, 0);

    done = 1'b1;
    report();
  end
endmodule